// File: doc/BRIEF.md
# Elapsed-Time Counter and Interval Timer Unit

This block is a real-time-clock peripheral that sits behind a 16-bit register bus. A 48-bit elapsed-time counter advances by one on every cycle where the 32.768 kHz tick enable is high. Its low 16-bit word therefore counts fractions of a second in units of 1/32768 s, and its upper 32 bits advance once every two seconds. Software sets the time by writing the upper and middle words into staging registers. A write to the low word then loads all three words into the counter at once. Reading the high word freezes a copy of the middle and low words, so a three-read sequence returns one coherent value.

An elapsed-compare register of 48 bits raises a pending flag when the counter steps onto its value. A compare value of zero turns the flag off. Two independent interval timers count down from a 32-bit reload value. The reload for an N Hz tick is 32768/N, so a 128 Hz tick uses a reload of 256. Each timer raises its own pending flag once per period. Writing zero as the reload stops that timer. Pending flags sit in a status register that clears on write-one, and the interrupt output is high while any flag is set.

Top module: `rtc_elapse_tmr`

## Requirements
- R1: After a synchronous active-low reset, every readable register returns 0 and `irq` is 0.
- R2: The 48-bit counter increases by exactly one on each cycle with `tick_en` high and holds its value otherwise. It wraps from all ones to zero.
- R3: Writes to address 2 (high word) and address 1 (middle word) only stage a value and leave the counter unchanged. A write to address 0 (low word) loads {staged high, staged middle, written data} in one cycle. That load takes priority over a tick in the same cycle.
- R4: A read of address 2 returns the live high word and captures the live middle and low words. Reads of address 1 and address 0 return those captured words until the next read of address 2.
- R5: Compare words are written at address 3 (low), 4 (middle) and 5 (high) and read back there. Status bit 0 is set on the tick that moves the counter onto a nonzero compare value.
- R6: While the compare value is zero, status bit 0 is never set, even when the counter wraps to zero.
- R7: Timer k (k = 0, 1) has its registers at base 8+4k: base+0 is the reload low half, base+1 the reload high half, base+2 the live count low half, base+3 the live count high half. A write to the reload low half loads the count with {reload high, written data}. Each tick then decrements the count. On a tick that finds the count at 1 or below, the timer sets its status bit (bit 1 for timer 0, bit 2 for timer 1) and reloads, which gives one event every reload ticks.
- R8: A timer whose reload value is zero holds its count and never sets its status bit.
- R9: The live count of each timer can be read at base+2 and base+3 at any time.
- R10: Status is at address 6, with bit 0 for compare, bit 1 for timer 0 and bit 2 for timer 1. Writing a one to a bit clears it, and writing 0xFFFF clears all of them. A new event in the same cycle wins over the clear.
- R11: `irq` is high exactly while at least one status bit is set, and it can only rise in the cycle after a tick.
- R12: The two timers run independently, and one timer's reload or events do not change the other.
- R13: Reads of unmapped addresses (7) and any read with `rd_en` low return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle enable at 32.768 kHz |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms the snapshot on address 2) |
| addr | input | 4 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from addr while rd_en is high |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The bench loads the counter next to a carry boundary of the low word and checks that staged upper words take effect only with the low-word write. A design that loaded each half on its own write would show a torn value there. It reads the high word, lets the counter run, and then reads the middle and low words. A missing snapshot would return the moved value. It sets the counter to all ones with a zero compare value, so a design that did not gate the match on a nonzero compare would raise a false compare event at the wrap. The timers are checked for their period, for the stop on a zero reload and for independence from each other. The status register is checked for write-one-clear on single bits and on all bits.

// File: rtl/rtc_pkg.sv
// rtc_pkg: shared widths and the register word map of the elapsed-time unit.
// Assumes one 16-bit word per address and a 4-bit word address.
package rtc_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int NUM_IV   = 2;
    localparam int IV_W     = 2 * DATA_W;
    localparam int TIME_W   = 3 * DATA_W;
    localparam int NUM_SRC  = NUM_IV + 1;

    localparam logic [ADDR_W-1:0] A_TIME_LO  = 4'd0;
    localparam logic [ADDR_W-1:0] A_TIME_MID = 4'd1;
    localparam logic [ADDR_W-1:0] A_TIME_HI  = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMP_LO   = 4'd3;
    localparam logic [ADDR_W-1:0] A_CMP_MID  = 4'd4;
    localparam logic [ADDR_W-1:0] A_CMP_HI   = 4'd5;
    localparam logic [ADDR_W-1:0] A_STAT     = 4'd6;
    localparam int                IV_BASE    = 8;
    localparam int                IV_STRIDE  = 4;

    // status bit positions
    localparam int PEND_CMP = 0;
    localparam int PEND_IV0 = 1;
endpackage

// File: rtl/rtc_elapse_cnt.sv
// rtc_elapse_cnt: 48-bit elapsed counter with staged upper words, a read
// snapshot of the lower words, and the elapsed-compare register and match.
// Assumes the bus never writes two words in one cycle.
module rtc_elapse_cnt #(
    parameter int DW = 16,
    localparam int TW = 3 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [2:0]    wr_time,   // one-hot: 0 low, 1 middle, 2 high
    input  logic [2:0]    wr_cmp,    // one-hot: 0 low, 1 middle, 2 high
    input  logic          rd_hi,
    input  logic [DW-1:0] wdata,
    output logic [TW-1:0] time_q,
    output logic [2*DW-1:0] snap_q,
    output logic [TW-1:0] cmp_q,
    output logic          cmp_hit
);
    logic [DW-1:0] stg_hi, stg_mid;
    logic [TW-1:0] time_inc;

    assign time_inc = time_q + TW'(1);

    // Event: the tick moves the counter onto a nonzero compare value.
    assign cmp_hit = tick_en && !wr_time[0] && (cmp_q != '0) && (time_inc == cmp_q);

    // Staging registers for the upper two counter words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_hi  <= '0;
            stg_mid <= '0;
        end else begin
            if (wr_time[2]) stg_hi  <= wdata;
            if (wr_time[1]) stg_mid <= wdata;
        end
    end

    // Counter: a low-word write loads all words, otherwise count on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)          time_q <= '0;
        else if (wr_time[0]) time_q <= {stg_hi, stg_mid, wdata};
        else if (tick_en)    time_q <= time_inc;
    end

    // Snapshot of the middle and low words taken on a high-word read.
    always_ff @(posedge clk) begin
        if (!rst_n)     snap_q <= '0;
        else if (rd_hi) snap_q <= time_q[2*DW-1:0];
    end

    // Compare words, each written on its own.
    for (genvar w = 0; w < 3; w++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (!rst_n)         cmp_q[w*DW +: DW] <= '0;
            else if (wr_cmp[w]) cmp_q[w*DW +: DW] <= wdata;
        end
    end
endmodule

// File: rtl/rtc_ival_timer.sv
// rtc_ival_timer: one reloadable periodic down-counter. A low-half reload
// write starts it; a zero reload keeps it idle. Assumes the high half is
// written before the low half.
module rtc_ival_timer #(
    parameter int DW = 16,
    localparam int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [1:0]    wr_rld,    // 0 low half, 1 high half
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] rld_q,
    output logic [CW-1:0] cnt_q,
    output logic          fire
);
    logic active;

    assign active = (rld_q != '0);
    assign fire   = tick_en && !wr_rld[0] && active && (cnt_q <= CW'(1));

    // Reload halves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else begin
            if (wr_rld[1]) rld_q[CW-1:DW] <= wdata;
            if (wr_rld[0]) rld_q[DW-1:0]  <= wdata;
        end
    end

    // Down-count: load on low write, reload on event, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (wr_rld[0])        cnt_q <= {rld_q[CW-1:DW], wdata};
        else if (fire)             cnt_q <= rld_q;
        else if (tick_en && active) cnt_q <= cnt_q - CW'(1);
    end
endmodule

// File: rtl/rtc_irq_stat.sv
// rtc_irq_stat: sticky pending bits with write-one-to-clear and an OR'd
// interrupt. A set in the same cycle as a clear wins.
module rtc_irq_stat #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_mask,
    output logic [NSRC-1:0] pend,
    output logic            irq
);
    // Pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= set | (pend & ~(clr_wr ? clr_mask : '0));
    end

    assign irq = |pend;
endmodule

// File: rtl/rtc_elapse_tmr.sv
// rtc_elapse_tmr: top of the elapsed-time / interval-timer unit. Decodes the
// word address, instantiates the counter, the timers and the status logic,
// and drives the combinational read mux. Assumes single-word accesses.
module rtc_elapse_tmr
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [2:0]           wr_time, wr_cmp;
    logic [TIME_W-1:0]    time_q, cmp_q;
    logic [2*DATA_W-1:0]  snap_q;
    logic                 cmp_hit;
    logic [IV_W-1:0]      iv_rld [NUM_IV];
    logic [IV_W-1:0]      iv_cnt [NUM_IV];
    logic [NUM_IV*IV_W-1:0] iv_rld_flat, iv_cnt_flat;
    logic [NUM_IV-1:0]    iv_fire;
    logic [NUM_SRC-1:0]   ev_set, pend;
    logic                 stat_wr;

    // Write strobes for the counter and compare words.
    assign wr_time = {wr_en && addr == A_TIME_HI, wr_en && addr == A_TIME_MID,
                      wr_en && addr == A_TIME_LO};
    assign wr_cmp  = {wr_en && addr == A_CMP_HI, wr_en && addr == A_CMP_MID,
                      wr_en && addr == A_CMP_LO};
    assign stat_wr = wr_en && addr == A_STAT;

    rtc_elapse_cnt #(.DW(DATA_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_time (wr_time),
        .wr_cmp  (wr_cmp),
        .rd_hi   (rd_en && addr == A_TIME_HI),
        .wdata   (wdata),
        .time_q  (time_q),
        .snap_q  (snap_q),
        .cmp_q   (cmp_q),
        .cmp_hit (cmp_hit)
    );

    for (genvar i = 0; i < NUM_IV; i++) begin : g_iv
        localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(IV_BASE + IV_STRIDE * i);
        localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(IV_BASE + IV_STRIDE * i + 1);

        rtc_ival_timer #(.DW(DATA_W)) u_iv (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_en (tick_en),
            .wr_rld  ({wr_en && addr == A_HI, wr_en && addr == A_LO}),
            .wdata   (wdata),
            .rld_q   (iv_rld[i]),
            .cnt_q   (iv_cnt[i]),
            .fire    (iv_fire[i])
        );
        assign iv_rld_flat[i*IV_W +: IV_W] = iv_rld[i];
        assign iv_cnt_flat[i*IV_W +: IV_W] = iv_cnt[i];
    end

    assign ev_set = {iv_fire, cmp_hit};

    rtc_irq_stat #(.NSRC(NUM_SRC)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set      (ev_set),
        .clr_wr   (stat_wr),
        .clr_mask (wdata[NUM_SRC-1:0]),
        .pend     (pend),
        .irq      (irq)
    );

    // Read mux: live high word, snapshot for middle/low, timers by base.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                A_TIME_LO:  rdata = snap_q[DATA_W-1:0];
                A_TIME_MID: rdata = snap_q[2*DATA_W-1:DATA_W];
                A_TIME_HI:  rdata = time_q[3*DATA_W-1:2*DATA_W];
                A_CMP_LO:   rdata = cmp_q[DATA_W-1:0];
                A_CMP_MID:  rdata = cmp_q[2*DATA_W-1:DATA_W];
                A_CMP_HI:   rdata = cmp_q[3*DATA_W-1:2*DATA_W];
                A_STAT:     rdata = DATA_W'(pend);
                default:    rdata = '0;
            endcase
            for (int i = 0; i < NUM_IV; i++) begin
                if (addr == ADDR_W'(IV_BASE + IV_STRIDE * i))     rdata = iv_rld[i][DATA_W-1:0];
                if (addr == ADDR_W'(IV_BASE + IV_STRIDE * i + 1)) rdata = iv_rld[i][IV_W-1:DATA_W];
                if (addr == ADDR_W'(IV_BASE + IV_STRIDE * i + 2)) rdata = iv_cnt[i][DATA_W-1:0];
                if (addr == ADDR_W'(IV_BASE + IV_STRIDE * i + 3)) rdata = iv_cnt[i][IV_W-1:DATA_W];
            end
        end
    end
endmodule

// File: rtl/rtc_elapse_tmr_chk.sv
// rtc_elapse_tmr_chk: temporal properties of rtc_elapse_tmr, bound to it.
module rtc_elapse_tmr_chk
    import rtc_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   tick_en,
    input logic                   wr_en,
    input logic [ADDR_W-1:0]      addr,
    input logic [DATA_W-1:0]      wdata,
    input logic                   irq,
    input logic [TIME_W-1:0]      time_q,
    input logic [TIME_W-1:0]      cmp_q,
    input logic                   cmp_hit,
    input logic [NUM_SRC-1:0]     pend,
    input logic [NUM_IV*IV_W-1:0] iv_rld_flat,
    input logic [NUM_IV*IV_W-1:0] iv_cnt_flat
);
    logic lo_wr;
    assign lo_wr = wr_en && addr == A_TIME_LO;

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en && !lo_wr |=> time_q == $past(time_q) + TIME_W'(1)); // R2
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en && !lo_wr |=> $stable(time_q)); // R3
    AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> time_q[DATA_W-1:0] == $past(wdata)); // R3
    AST_CMP_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_q == '0 |-> !cmp_hit); // R6
    AST_IRQ_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(tick_en)); // R11
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && addr == A_STAT && wdata[PEND_CMP] && !cmp_hit |=> !pend[PEND_CMP]); // R10

    for (genvar i = 0; i < NUM_IV; i++) begin : g_iv_chk
        localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(IV_BASE + IV_STRIDE * i);
        AST_IV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            iv_rld_flat[i*IV_W +: IV_W] == '0 && iv_cnt_flat[i*IV_W +: IV_W] == '0
            && !(wr_en && addr == A_LO)
            |=> iv_cnt_flat[i*IV_W +: IV_W] == '0 && !pend[PEND_IV0 + i]); // R8
    end
endmodule

bind rtc_elapse_tmr rtc_elapse_tmr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .irq         (irq),
    .time_q      (time_q),
    .cmp_q       (cmp_q),
    .cmp_hit     (cmp_hit),
    .pend        (pend),
    .iv_rld_flat (iv_rld_flat),
    .iv_cnt_flat (iv_cnt_flat)
);

// File: tb/test_rtc_elapse_tmr.sv
// Bench: behavioural reference model updated on every rising edge, the
// interrupt compared on every falling edge, and reads compared to the model.
module test_rtc_elapse_tmr;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        tick_on = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    rtc_elapse_tmr i_rtc_elapse_tmr (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always @(negedge clk) tick_en <= tick_on;

    // ---------------- reference model ----------------
    logic [47:0] m_time, m_cmp, m_next;
    logic [15:0] m_stg_hi, m_stg_mid;
    logic [31:0] m_snap;
    logic [31:0] m_rld [2];
    logic [31:0] m_cnt [2];
    logic [2:0]  m_pend, m_set;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_time = '0; m_cmp = '0; m_stg_hi = '0; m_stg_mid = '0; m_snap = '0;
            m_pend = '0;
            for (int i = 0; i < 2; i++) begin m_rld[i] = '0; m_cnt[i] = '0; end
        end else begin
            m_set = '0;
            m_next = m_time;
            if (wr_en && addr == 4'd0) m_next = {m_stg_hi, m_stg_mid, wdata};
            else if (tick_en) begin
                m_next = m_time + 48'd1;
                if (m_cmp != 0 && m_next == m_cmp) m_set[0] = 1'b1;
            end
            if (rd_en && addr == 4'd2) m_snap = m_time[31:0];
            if (wr_en && addr == 4'd2) m_stg_hi = wdata;
            if (wr_en && addr == 4'd1) m_stg_mid = wdata;
            if (wr_en && addr == 4'd3) m_cmp[15:0] = wdata;
            if (wr_en && addr == 4'd4) m_cmp[31:16] = wdata;
            if (wr_en && addr == 4'd5) m_cmp[47:32] = wdata;
            for (int i = 0; i < 2; i++) begin
                if (wr_en && addr == 4'(8 + 4 * i)) m_cnt[i] = {m_rld[i][31:16], wdata};
                else if (tick_en && m_rld[i] != 0) begin
                    if (m_cnt[i] <= 1) begin m_set[i+1] = 1'b1; m_cnt[i] = m_rld[i]; end
                    else m_cnt[i] = m_cnt[i] - 1;
                end
                if (wr_en && addr == 4'(8 + 4 * i))     m_rld[i][15:0]  = wdata;
                if (wr_en && addr == 4'(8 + 4 * i + 1)) m_rld[i][31:16] = wdata;
            end
            m_pend = m_set | (m_pend & ~((wr_en && addr == 4'd6) ? wdata[2:0] : 3'b000));
            m_time = m_next;
        end
    end

    function automatic logic [15:0] model_rd(input logic [3:0] a);
        case (a)
            4'd0: return m_snap[15:0];
            4'd1: return m_snap[31:16];
            4'd2: return m_time[47:32];
            4'd3: return m_cmp[15:0];
            4'd4: return m_cmp[31:16];
            4'd5: return m_cmp[47:32];
            4'd6: return {13'd0, m_pend};
            4'd8:  return m_rld[0][15:0];
            4'd9:  return m_rld[0][31:16];
            4'd10: return m_cnt[0][15:0];
            4'd11: return m_cnt[0][31:16];
            4'd12: return m_rld[1][15:0];
            4'd13: return m_rld[1][31:16];
            4'd14: return m_cnt[1][15:0];
            4'd15: return m_cnt[1][31:16];
            default: return 16'd0;
        endcase
    endfunction

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, got, exp);
        end
    endtask

    // R11: irq compared against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #1;
            check({15'd0, irq}, {15'd0, |m_pend}, "R11 irq vs pending");
        end
    end

    // ---------------- bus tasks ----------------
    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            wr_en = 1'b0; rd_en = 1'b0;
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    endtask

    // Read, compare to the model and optionally to a literal value.
    task automatic rd(input logic [3:0] a, input string tag,
                      input bit use_lit = 1'b0, input logic [15:0] lit = '0);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b1; addr = a;
        #2;
        check(rdata, model_rd(a), tag);
        if (use_lit) check(rdata, lit, tag);
    endtask

    task automatic load_time(input logic [15:0] h, input logic [15:0] m, input logic [15:0] l);
        wr(4'd2, h); wr(4'd1, m); wr(4'd0, l);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R0 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(4'd2, "R1 time hi", 1, 16'd0);
        rd(4'd0, "R1 time lo", 1, 16'd0);
        rd(4'd6, "R1 status", 1, 16'd0);
        rd(4'd10, "R1 iv0 count", 1, 16'd0);
        check({15'd0, irq}, 16'd0, "R1 irq");

        // R2: free running count
        tick_on = 1'b1; idle(12); tick_on = 1'b0; idle(2);
        rd(4'd2, "R2 hi"); rd(4'd1, "R2 mid"); rd(4'd0, "R2 lo");

        // R3: staging does not touch the counter; low write loads all
        wr(4'd2, 16'h0001); wr(4'd1, 16'h0002); idle(2);
        rd(4'd2, "R3 hi after staging", 1, 16'h0000);
        wr(4'd0, 16'hFFFE); idle(1);
        rd(4'd2, "R3 hi after load", 1, 16'h0001);
        rd(4'd1, "R3 mid after load", 1, 16'h0002);
        rd(4'd0, "R3 lo after load", 1, 16'hFFFE);
        tick_on = 1'b1; idle(4); tick_on = 1'b0; idle(2);
        rd(4'd2, "R2 carry hi"); rd(4'd1, "R2 carry mid"); rd(4'd0, "R2 carry lo");

        // R4: snapshot stays coherent while the counter moves
        load_time(16'h0001, 16'h0002, 16'hFFFF); idle(1);
        rd(4'd2, "R4 hi live", 1, 16'h0001);
        tick_on = 1'b1; idle(5); tick_on = 1'b0; idle(2);
        rd(4'd1, "R4 mid snapshot", 1, 16'h0002);
        rd(4'd0, "R4 lo snapshot", 1, 16'hFFFF);
        rd(4'd2, "R4 hi re-read"); rd(4'd0, "R4 lo new snapshot");

        // R5: compare event
        load_time(16'h0000, 16'h0000, 16'h0010);
        wr(4'd5, 16'h0000); wr(4'd4, 16'h0000); wr(4'd3, 16'h0015); idle(1);
        rd(4'd3, "R5 cmp readback", 1, 16'h0015);
        tick_on = 1'b1; idle(12); tick_on = 1'b0; idle(2);
        rd(4'd6, "R5 status bit0", 1, 16'h0001);
        // R10: write-one-to-clear of one bit
        wr(4'd6, 16'h0001); idle(1);
        rd(4'd6, "R10 status cleared", 1, 16'h0000);

        // R6: zero compare, counter wraps to zero
        wr(4'd3, 16'h0000); wr(4'd4, 16'h0000); wr(4'd5, 16'h0000);
        load_time(16'hFFFF, 16'hFFFF, 16'hFFFD);
        tick_on = 1'b1; idle(8); tick_on = 1'b0; idle(2);
        rd(4'd6, "R6 no compare event", 1, 16'h0000);
        rd(4'd2, "R2 wrap hi", 1, 16'h0000);

        // R7/R9: timer 0 with reload 5
        wr(4'd9, 16'h0000); wr(4'd8, 16'h0005); idle(1);
        rd(4'd10, "R9 count lo after load", 1, 16'h0005);
        rd(4'd11, "R9 count hi after load", 1, 16'h0000);
        tick_on = 1'b1; idle(3); tick_on = 1'b0; idle(2);
        rd(4'd10, "R9 count mid-run");
        tick_on = 1'b1; idle(9); tick_on = 1'b0; idle(2);
        rd(4'd6, "R7 timer0 event", 1, 16'h0002);
        rd(4'd10, "R7 count after reload");

        // R10/R11: clear all with 0xFFFF
        wr(4'd6, 16'hFFFF); idle(1);
        rd(4'd6, "R10 clear all", 1, 16'h0000);
        check({15'd0, irq}, 16'd0, "R11 irq low after clear");

        // R8: zero reload stops timer 0; R12: timer 1 runs alone
        wr(4'd8, 16'h0000); idle(1);
        wr(4'd13, 16'h0000); wr(4'd12, 16'h0003);
        tick_on = 1'b1; idle(20); tick_on = 1'b0; idle(2);
        rd(4'd10, "R8 idle count", 1, 16'h0000);
        rd(4'd6, "R12 only timer1 event", 1, 16'h0004);
        rd(4'd14, "R12 timer1 count");

        // timer 1 period with a high-half reload
        wr(4'd6, 16'hFFFF);
        wr(4'd13, 16'h0001); wr(4'd12, 16'h0000); idle(1);
        rd(4'd15, "R9 timer1 count hi", 1, 16'h0001);
        rd(4'd14, "R9 timer1 count lo", 1, 16'h0000);

        // R13: unmapped address and reads with rd_en low
        rd(4'd7, "R13 unmapped", 1, 16'h0000);
        @(negedge clk); rd_en = 1'b0; addr = 4'd2; #2;
        check(rdata, 16'h0000, "R13 rd_en low");

        idle(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule